// File: doc/BRIEF.md
# Shared Tagged Multi-Port Receive FIFO

This block is one receive buffer shared by many logical ports. Each word that arrives from a channelized receive bus is stored with an 8-bit port tag and its start-of-packet and end-of-packet flags. Words leave in strict arrival order, and each one carries its tag, so the reader sees a single stream and cannot choose a port. Packets from different ports may be interleaved in the stream. Because of this, the tag may change between two words of the same packet.

A single fill counter drives all flow control. The fill level is compared with a global almost-empty level and a global almost-full level. The result is reported as the status of every port. When override is enabled, status values supplied from outside take the place of the computed ones, port by port. A write that arrives while the buffer is full is dropped and raises a one-cycle overflow pulse. An underflow warning is raised while the fill level is below a low-water level.

The read side is show-ahead. While `rd_valid` is high, the head word is already on the read outputs, and `rd_en` consumes it at the next clock edge.

Top module: `shared_tag_fifo`

## Requirements
- R1: A word read out has the same data, 8-bit tag, start flag and end flag as when it was written. All 8 tag bits pass through unchanged, whatever NUM_PORTS is.
- R2: Words are read out in the order they were accepted, across all ports. This holds when packets of different ports are interleaved.
- R3: `fill_level` equals accepted writes minus accepted reads. `full` is high exactly when `fill_level` equals DEPTH. `rd_valid` is high exactly when `fill_level` is above zero. These outputs change at the edge that accepts the operation.
- R4: A write while full, with no read in the same cycle, is dropped. `overflow_err` is high for exactly the one cycle after that edge, and the stored contents are unchanged.
- R5: A read and a write in the same cycle while full are both accepted. `fill_level` stays at DEPTH and no overflow is flagged.
- R6: A read request while empty is ignored, and `fill_level` stays zero.
- R7: With override off, every port reports the same 2-bit status, with port p at bits [2p+1:2p]. The codes are 2'b00 starving when fill <= `ae_level`, 2'b10 satisfied when fill >= `af_level`, and 2'b01 hungry otherwise. Starving has priority.
- R8: With override on, `port_status` equals `ovr_status` bit for bit.
- R9: `underflow_warn` is high exactly while `fill_level` < `low_level`.
- R10: After reset, the fill level is zero, `rd_valid`, `full` and `overflow_err` are low, and all ports report starving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| wr_tag | input | 8 | Port tag of the written word |
| wr_sop | input | 1 | Start-of-packet flag of the written word |
| wr_eop | input | 1 | End-of-packet flag of the written word |
| rd_en | input | 1 | Consume the head word |
| rd_valid | output | 1 | Head word present |
| rd_data | output | DATA_W | Head word data |
| rd_tag | output | 8 | Head word port tag |
| rd_sop | output | 1 | Head word start flag |
| rd_eop | output | 1 | Head word end flag |
| fill_level | output | CNT_W | Words currently stored |
| full | output | 1 | Buffer holds DEPTH words |
| overflow_err | output | 1 | One-cycle pulse after a dropped write |
| ae_level | input | CNT_W | Almost-empty level |
| af_level | input | CNT_W | Almost-full level |
| low_level | input | CNT_W | Underflow warning level |
| underflow_warn | output | 1 | Fill level below `low_level` |
| ovr_en | input | 1 | Use external per-port status |
| ovr_status | input | 2*NUM_PORTS | External per-port status |
| port_status | output | 2*NUM_PORTS | Per-port flow-control status |

## Verification
An accepted write appears on the read outputs after the one edge that stores it. `fill_level`, `full`, `rd_valid`, `port_status` and `underflow_warn` are all decoded from the fill register, so they change at that same edge. `overflow_err` is registered, so it rises for the single cycle after the edge that drops the write. The bench drives inputs at the falling edge and compares the head word just before the rising edge that consumes it. It checks every counter-derived output and the overflow pulse at the next falling edge, using its own queue model.

// File: rtl/stf_pkg.sv
package stf_pkg;
  localparam int TAG_W = 8;

  typedef enum logic [1:0] {
    ST_STARVING  = 2'b00,
    ST_HUNGRY    = 2'b01,
    ST_SATISFIED = 2'b10
  } fc_state_e;

  // Map the shared fill level onto a flow-control state; starving wins ties.
  function automatic fc_state_e classify_fill(input int unsigned fill,
                                              input int unsigned ae,
                                              input int unsigned af);
    if (fill <= ae)      return ST_STARVING;
    else if (fill >= af) return ST_SATISFIED;
    else                 return ST_HUNGRY;
  endfunction

  // Circular pointer advance for any depth.
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/stf_storage.sv
module stf_storage
  import stf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int WORD_W = DATA_W + TAG_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_accept,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_accept,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_accept) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_accept) wr_ptr <= PTR_W'(ptr_step(32'(wr_ptr), DEPTH));
      if (rd_accept) rd_ptr <= PTR_W'(ptr_step(32'(rd_ptr), DEPTH));
    end
  end

  assign rd_word = mem[rd_ptr];
endmodule

// File: rtl/stf_fill_ctr.sv
module stf_fill_ctr #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             rd_req,
  output logic [CNT_W-1:0] fill,
  output logic             full,
  output logic             empty,
  output logic             wr_accept,
  output logic             rd_accept,
  output logic             overflow_err
);
  logic drop_evt;

  assign empty     = (fill == '0);
  assign full      = (fill == CNT_W'(DEPTH));
  assign rd_accept = rd_req && !empty;
  assign wr_accept = wr_req && (!full || rd_accept);
  assign drop_evt  = wr_req && !wr_accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill         <= '0;
      overflow_err <= 1'b0;
    end else begin
      overflow_err <= drop_evt;
      case ({wr_accept, rd_accept})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R3
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH)) else $error("fill above depth");

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (overflow_err && fill == $past(fill))) else $error("dropped write changed state");

  // R5
  full_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && rd_req) |=> (full && !overflow_err)) else $error("full read+write mishandled");

  // R6
  empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && !wr_req) |=> empty) else $error("read from empty changed fill");
endmodule

// File: rtl/stf_status_gen.sv
module stf_status_gen
  import stf_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 5
) (
  input  logic [CNT_W-1:0]       fill,
  input  logic [CNT_W-1:0]       ae_level,
  input  logic [CNT_W-1:0]       af_level,
  input  logic                   ovr_en,
  input  logic [2*NUM_PORTS-1:0] ovr_status,
  output logic [2*NUM_PORTS-1:0] port_status
);
  fc_state_e shared_state;

  assign shared_state = classify_fill(32'(fill), 32'(ae_level), 32'(af_level));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_status[2*p +: 2] = ovr_en ? ovr_status[2*p +: 2] : shared_state;
  end

  always_comb begin
    if (!ovr_en && fill == '0) begin
      // R7
      empty_starving_chk: assert (port_status[1:0] == 2'b00) else $error("empty buffer not starving");
    end
    for (int q = 0; q < NUM_PORTS; q++) begin
      if (!ovr_en) begin
        // R7
        legal_code_chk: assert (port_status[2*q +: 2] != 2'b11) else $error("illegal status code");
      end
    end
  end
endmodule

// File: rtl/shared_tag_fifo.sv
module shared_tag_fifo
  import stf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 16,
  parameter int NUM_PORTS = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [TAG_W-1:0]       wr_tag,
  input  logic                   wr_sop,
  input  logic                   wr_eop,
  input  logic                   rd_en,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  output logic [TAG_W-1:0]       rd_tag,
  output logic                   rd_sop,
  output logic                   rd_eop,
  output logic [CNT_W-1:0]       fill_level,
  output logic                   full,
  output logic                   overflow_err,
  input  logic [CNT_W-1:0]       ae_level,
  input  logic [CNT_W-1:0]       af_level,
  input  logic [CNT_W-1:0]       low_level,
  output logic                   underflow_warn,
  input  logic                   ovr_en,
  input  logic [2*NUM_PORTS-1:0] ovr_status,
  output logic [2*NUM_PORTS-1:0] port_status
);
  localparam int WORD_W = DATA_W + TAG_W + 2;

  logic              wr_accept;
  logic              rd_accept;
  logic              empty;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] head_word;

  assign wr_word = {wr_tag, wr_sop, wr_eop, wr_data};

  stf_fill_ctr #(.DEPTH(DEPTH)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_valid), .rd_req(rd_en),
    .fill(fill_level), .full(full), .empty(empty),
    .wr_accept(wr_accept), .rd_accept(rd_accept),
    .overflow_err(overflow_err)
  );

  stf_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_accept(wr_accept), .wr_word(wr_word),
    .rd_accept(rd_accept), .rd_word(head_word)
  );

  stf_status_gen #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) u_status (
    .fill(fill_level), .ae_level(ae_level), .af_level(af_level),
    .ovr_en(ovr_en), .ovr_status(ovr_status), .port_status(port_status)
  );

  assign rd_valid       = !empty;
  assign {rd_tag, rd_sop, rd_eop, rd_data} = head_word;
  assign underflow_warn = (fill_level < low_level);

  // R1
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_en) |=> $stable(head_word)) else $error("head word changed without a read");
endmodule

// File: tb/shared_tag_fifo_tb.sv
`timescale 1ns/1ps
module shared_tag_fifo_tb_top;
  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int NP = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic wr_valid, wr_sop, wr_eop, rd_en, ovr_en;
  logic [DW-1:0] wr_data;
  logic [7:0] wr_tag;
  logic rd_valid, rd_sop, rd_eop, full, overflow_err, underflow_warn;
  logic [DW-1:0] rd_data;
  logic [7:0] rd_tag;
  logic [CW-1:0] fill_level, ae_level, af_level, low_level;
  logic [2*NP-1:0] ovr_status, port_status;

  always #2.5 clk = ~clk;

  shared_tag_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .NUM_PORTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_tag(wr_tag),
    .wr_sop(wr_sop), .wr_eop(wr_eop), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_tag(rd_tag), .rd_sop(rd_sop), .rd_eop(rd_eop), .fill_level(fill_level), .full(full),
    .overflow_err(overflow_err), .ae_level(ae_level), .af_level(af_level), .low_level(low_level),
    .underflow_warn(underflow_warn), .ovr_en(ovr_en), .ovr_status(ovr_status),
    .port_status(port_status)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  int model_cnt = 0;
  logic [41:0] exp_q[$];

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [2*NP-1:0] want_status(input int cnt);
    logic [1:0] code;
    logic [2*NP-1:0] r;
    if (ovr_en) return ovr_status;
    if (cnt > int'(ae_level) && cnt < int'(af_level)) code = 2'b01;
    else if (cnt > int'(ae_level)) code = 2'b10;
    else code = 2'b00;
    for (int p = 0; p < NP; p++) r[2*p +: 2] = code;
    return r;
  endfunction

  // Starts and ends at a falling edge.
  task automatic cycle(input bit wv, input logic [31:0] d, input logic [7:0] t,
                       input bit s, input bit e, input bit re);
    bit racc, wacc, drop;
    wr_valid = wv; wr_data = d; wr_tag = t; wr_sop = s; wr_eop = e; rd_en = re;
    #1;
    racc = re && model_cnt > 0;
    wacc = wv && (model_cnt < DEPTH || racc);
    drop = wv && !wacc;
    if (racc) check("R1/R2 head word", 64'({rd_tag, rd_sop, rd_eop, rd_data}), 64'(exp_q[0]));
    @(posedge clk);
    @(negedge clk);
    if (racc) begin void'(exp_q.pop_front()); model_cnt--; end
    if (wacc) begin exp_q.push_back({t, s, e, d}); model_cnt++; end
    wr_valid = 0; rd_en = 0;
    check("R3 fill_level", 64'(fill_level), 64'(model_cnt));
    check("R3 full", 64'(full), 64'(model_cnt == DEPTH));
    check("R3 rd_valid", 64'(rd_valid), 64'(model_cnt > 0));
    check("R4 overflow_err", 64'(overflow_err), 64'(drop));
    check(ovr_en ? "R8 port_status" : "R7 port_status", 64'(port_status), 64'(want_status(model_cnt)));
    check("R9 underflow_warn", 64'(underflow_warn), 64'(model_cnt < int'(low_level)));
  endtask

  task automatic drain();
    while (model_cnt > 0) cycle(0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_reset();
    rst_n = 0; wr_valid = 0; rd_en = 0; wr_data = 0; wr_tag = 0; wr_sop = 0; wr_eop = 0;
    ovr_en = 0; ovr_status = 0; ae_level = 4; af_level = 12; low_level = 2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R10 fill", 64'(fill_level), 0);
    check("R10 rd_valid", 64'(rd_valid), 0);
    check("R10 full", 64'(full), 0);
    check("R10 overflow", 64'(overflow_err), 0);
    check("R10 status", 64'(port_status), 0);
  endtask

  task automatic t_interleave();
    // R2: ports 2 and 3 interleave; tag 8'hC6 exercises upper tag bits for R1
    cycle(1, 32'h1111_0001, 8'h02, 1, 0, 0);
    cycle(1, 32'h2222_0001, 8'h03, 1, 0, 0);
    cycle(1, 32'h1111_0002, 8'h02, 0, 0, 0);
    cycle(1, 32'h2222_0002, 8'h03, 0, 1, 0);
    cycle(1, 32'h3333_0001, 8'hC6, 1, 1, 0);
    cycle(1, 32'h1111_0003, 8'h02, 0, 1, 1);
    drain();
  endtask

  task automatic t_ramp_overflow();
    for (int i = 0; i < DEPTH; i++) cycle(1, 32'hA000_0000 + i, 8'(i % NP), i == 0, 0, 0);
    cycle(1, 32'hDEAD_BEEF, 8'hFF, 1, 1, 0);   // R4: dropped
    cycle(0, 0, 0, 0, 0, 0);                   // R4: pulse ends
    check("R4 fill after drop", 64'(fill_level), DEPTH);
    drain();
  endtask

  task automatic t_full_rw();
    for (int i = 0; i < DEPTH; i++) cycle(1, 32'hB000_0000 + i, 8'(3 - i % NP), 0, 0, 0);
    cycle(1, 32'hB0B0_0000, 8'h01, 0, 1, 1);
    check("R5 fill stays full", 64'(fill_level), DEPTH);
    check("R5 no overflow", 64'(overflow_err), 0);
    drain();
  endtask

  task automatic t_override();
    ovr_en = 1; ovr_status = 8'b10_01_00_10;
    cycle(1, 32'hC000_0001, 8'h00, 1, 1, 0);
    ovr_status = 8'b00_10_01_00;
    cycle(0, 0, 0, 0, 0, 0);
    check("R8 override pattern", 64'(port_status), 64'(8'b00_10_01_00));
    ovr_en = 0;
    cycle(0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_empty_read();
    cycle(0, 0, 0, 0, 0, 1);
    check("R6 fill stays zero", 64'(fill_level), 0);
    check("R6 rd_valid low", 64'(rd_valid), 0);
    cycle(1, 32'hD000_0001, 8'h05, 1, 1, 1);
    check("R6 write with read on empty", 64'(fill_level), 1);
    drain();
  endtask

  initial begin
    t_reset();
    t_interleave();
    t_ramp_overflow();
    t_full_rw();
    t_override();
    t_empty_read();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule